// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block is the transmit half of a serial port. A producer (software or a DMA-style requester) places an 8-bit character into a one-entry holding register. The block then moves that character into a shift register and sends it on a single serial line. Each frame is a low start bit, the eight data bits with the least significant bit first, an optional parity bit, and one high stop bit. Every bit lasts a fixed number of pulses of an external baud-tick enable, so the block needs no divider of its own.

Two status flags tell the producer what to do next. `tx_ready` says the holding register can take a character. `tx_empty` says that everything written has left the line, up to and including the last stop bit. Because of the holding register, the next character can be written while the current one is still shifting out, and frames then follow each other with no idle time between them.

The shift engine is a state machine with five states. `ST_IDLE` waits with the line high. `ST_START` drives the start bit. `ST_DATA` sends the data bits. `ST_PARITY` sends the parity bit when one is selected. `ST_STOP` drives the stop bit. Its transitions are:

- IDLE to START on a baud tick while the holding register is full. The character is loaded on that tick.
- START to DATA at the end of the start bit.
- DATA to DATA after each data bit except the last.
- DATA to PARITY, or to STOP when no parity is selected, after the last data bit.
- PARITY to STOP at the end of the parity bit.
- STOP to START at the end of the stop bit when a character is waiting. That character is loaded on the same tick.
- STOP to IDLE at the end of the stop bit when no character is waiting.
- Any state to IDLE while the transmitter is disabled.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While `tx_en` is low, the state machine is held in IDLE, the holding register is cleared, `tx_ready` and `tx_empty` are 0, and `txd` is 1. Dropping `tx_en` in the middle of a frame abandons that frame.
- R2: One clock after `tx_en` rises with nothing pending, `tx_ready` and `tx_empty` are both 1.
- R3: A frame is: a start bit (0), then data bits D0 to D7 least significant bit first, then the parity bit when one is selected, then one stop bit (1). Each bit lasts TICKS_PER_BIT baud ticks (16 by default), and `txd` changes only on clock edges where `baud_tick` is 1.
- R4: `par_mode` is sampled when a character is loaded. The codes are: 0 = no parity bit, 1 = even (parity bit = XOR of the data), 2 = odd (parity bit = inverted XOR of the data), 3 = parity bit fixed at 0, 4 = parity bit fixed at 1. Codes 5 to 7 add no parity bit.
- R5: A write (`wr_stb` high for one clock) is accepted when `tx_ready` is 1. `tx_ready` is 0 in the following cycle.
- R6: When the shifter is idle, a held character is loaded on the next clock edge that has `baud_tick` high, and `tx_ready` returns to 1 after that edge. Without a baud tick, nothing is loaded.
- R7: A write while `tx_ready` is 0 is ignored. The character already held is kept, and the ignored character never appears on `txd`.
- R8: A character written while another is shifting keeps `tx_ready` at 0 until the first stop bit completes. On the tick that completes the stop bit, the second character is loaded and its start bit begins, with no idle bit time between the frames, and `tx_ready` rises again.
- R9: `tx_empty` is 1 only when the holding register is empty and the shifter is idle. After the last frame it rises on the tick that completes the stop bit.
- R10: When no character is pending, `txd` idles at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable. Low clears the block. |
| par_mode | input | 3 | Parity selection code (see R4) |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| baud_tick | input | 1 | Baud-rate enable pulse, TICKS_PER_BIT per bit |
| tx_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Holding register and shifter are both empty |
| txd | output | 1 | Serial output line |

## Verification
The hardest condition to reach is the reload from the holding register at the exact tick that ends a stop bit. Random ticks and writes land there only by chance. To make it certain, the stimulus stops the baud ticks and issues one forced tick to load the first character. It then writes the second character, with a write that must be ignored alongside it, while the first frame is running. A line monitor then measures the tick distance between the two start bits and checks that the second frame starts on the tick that ends the first stop bit. Random rounds then vary the parity codes, the characters and the spacing of writes and ticks, and a line decoder compares every frame against the accepted characters.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    localparam logic [2:0] PM_NONE  = 3'd0;
    localparam logic [2:0] PM_EVEN  = 3'd1;
    localparam logic [2:0] PM_ODD   = 3'd2;
    localparam logic [2:0] PM_SPACE = 3'd3;
    localparam logic [2:0] PM_MARK  = 3'd4;

    // True when the mode code inserts a parity bit into the frame
    function automatic logic par_present(input logic [2:0] mode);
        return (mode == PM_EVEN) || (mode == PM_ODD) ||
               (mode == PM_SPACE) || (mode == PM_MARK);
    endfunction

    // Parity bit value, given the XOR reduction of the data bits
    function automatic logic par_pick(input logic [2:0] mode, input logic data_xor);
        logic r;
        unique case (mode)
            PM_EVEN:  r = data_xor;
            PM_ODD:   r = ~data_xor;
            PM_MARK:  r = 1'b1;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    // One-entry holding register; writes while full are dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!en) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/utx_bitclk.sv
module utx_bitclk #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic baud_tick,
    output logic bit_end
);

    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_comb bit_end = !clr && baud_tick && (cnt == LAST);

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          baud_tick,
    input  logic          bit_end,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic [2:0]    par_mode,
    output logic          take,
    output logic          txd,
    output logic          idle
);

    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

    tx_state_e     state, state_nx;
    logic [DW-1:0] sh;
    logic [IW-1:0] idx;
    logic          par_on, par_val;

    // Load request: from idle on any tick, or chained at the stop-bit end
    always_comb take = en && baud_tick && hold_full &&
                       ((state == ST_IDLE) || ((state == ST_STOP) && bit_end));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take) state_nx = ST_START;
            ST_START:  if (bit_end) state_nx = ST_DATA;
            ST_DATA:   if (bit_end && (idx == IDX_LAST))
                           state_nx = par_on ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_nx = ST_STOP;
            ST_STOP:   if (bit_end) state_nx = take ? ST_START : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= ST_IDLE;
        else if (!en)  state <= ST_IDLE;
        else           state <= state_nx;
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            idx     <= '0;
            par_on  <= 1'b0;
            par_val <= 1'b0;
        end else if (!en) begin
            sh      <= '0;
            idx     <= '0;
            par_on  <= 1'b0;
            par_val <= 1'b0;
        end else if (take) begin
            sh      <= hold_data;
            idx     <= '0;
            par_on  <= par_present(par_mode);
            par_val <= par_pick(par_mode, ^hold_data);
        end else if (bit_end && (state == ST_DATA)) begin
            sh  <= sh >> 1;
            idx <= idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh[0];
            ST_PARITY: txd = par_val;
            default:   txd = 1'b1;
        endcase
        idle = (state == ST_IDLE);
    end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [2:0]        par_mode,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              txd
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              idle;
    logic              bit_end;

    utx_hold #(.DW(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_en),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    utx_bitclk #(.TICKS(TICKS_PER_BIT)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!tx_en || idle),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    utx_shifter #(.DW(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .baud_tick (baud_tick),
        .bit_end   (bit_end),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .par_mode  (par_mode),
        .take      (take),
        .txd       (txd),
        .idle      (idle)
    );

    always_comb begin
        tx_ready = tx_en && !hold_full;
        tx_empty = tx_en && !hold_full && idle;
    end

endmodule

// File: rtl/utx_chk.sv
module utx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_stb,
    input logic baud_tick,
    input logic tx_ready,
    input logic tx_empty,
    input logic txd
);

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && $past(!tx_en)) |-> (!tx_ready && !tx_empty && txd));

    // R5
    write_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && wr_stb) |=> !tx_ready);

    // R3
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> $past(baud_tick));

    // R9
    empty_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

    // R10
    empty_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

endmodule

bind uart_tx_dbuf utx_chk i_utx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .wr_stb    (wr_stb),
    .baud_tick (baud_tick),
    .tx_ready  (tx_ready),
    .tx_empty  (tx_empty),
    .txd       (txd)
);

// File: tb/test_uart_tx_dbuf.sv
module test_uart_tx_dbuf;

    localparam int TPB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       baud_tick = 1'b0;
    logic       tx_ready, tx_empty, txd;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    uart_tx_dbuf i_uart_tx_dbuf (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .par_mode(par_mode),
        .wr_stb(wr_stb), .wr_data(wr_data), .baud_tick(baud_tick),
        .tx_ready(tx_ready), .tx_empty(tx_empty), .txd(txd)
    );

    function automatic bit has_par(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

    function automatic logic par_of(input logic [2:0] m, input logic [7:0] d);
        case (m)
            3'd1: return ^d;
            3'd2: return ~^d;
            3'd4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Baud tick source: random when enabled, otherwise set by tasks
    bit tick_rand = 1'b0;
    always @(negedge clk) if (tick_rand) baud_tick <= ($urandom % 2 == 0);

    logic tick_seen = 1'b0;
    always @(posedge clk) tick_seen <= baud_tick;

    // Line monitor: expected characters with their parity mode
    logic [10:0] expq[$];
    bit          in_frame = 1'b0;
    int          n = 0, since = 0, last_gap = 0, nb_cur = 10, nb_last = 10;
    int          frames_done = 0;
    logic [10:0] cur;
    bit          empty_prev = 1'b0;

    always @(negedge clk) begin
        if (!tx_en) begin
            in_frame = 1'b0;
        end else if (tick_seen) begin
            since++;
            if (!in_frame) begin
                if (txd == 1'b0) begin
                    in_frame = 1'b1;
                    n = 0;
                    last_gap = since;
                    since = 0;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R7 unexpected frame", 1, 0);
                        cur = 11'd0;
                    end else begin
                        cur = expq.pop_front();
                    end
                    nb_cur = has_par(cur[10:8]) ? 11 : 10;
                end
            end else begin
                n++;
            end
            if (in_frame && (n % TPB == TPB / 2)) begin
                int  bi;
                logic e;
                bi = n / TPB;
                if (bi == 0)                      e = 1'b0;
                else if (bi <= 8)                 e = cur[bi-1];
                else if (bi == 9 && nb_cur == 11) e = par_of(cur[10:8], cur[7:0]);
                else                              e = 1'b1;
                chk(txd == e, (bi == 9 && nb_cur == 11) ? "R4 parity bit" : "R3 frame bit",
                    int'(txd), int'(e));
                if (bi == nb_cur - 1) begin
                    chk(!tx_empty, "R9 empty during stop bit", int'(tx_empty), 0);
                    in_frame = 1'b0;
                    nb_last = nb_cur;
                    frames_done++;
                end
            end
            if (tx_empty && !empty_prev && frames_done > 0)
                chk(since == TPB * nb_last, "R9 empty after last stop tick", since, TPB * nb_last);
        end
        empty_prev = tx_empty;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic write(input logic [7:0] d, output bit acc);
        acc = tx_ready;
        wr_stb = 1'b1;
        wr_data = d;
        if (acc) expq.push_back({par_mode, d});
        step();
        wr_stb = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 20000 && !tx_empty; i++) step();
        chk(tx_empty, "R9 reaches empty", int'(tx_empty), 1);
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit acc;
        void'($urandom(32'h5EED_1234));
        step(); step();
        rst_n = 1'b1;
        step();
        // R1: disabled after reset
        chk(!tx_ready, "R1 ready low when disabled", int'(tx_ready), 0);
        chk(!tx_empty, "R1 empty low when disabled", int'(tx_empty), 0);
        chk(txd, "R1 line high when disabled", int'(txd), 1);

        tx_en = 1'b1;
        step();
        chk(tx_ready, "R2 ready after enable", int'(tx_ready), 1);
        chk(tx_empty, "R2 empty after enable", int'(tx_empty), 1);
        chk(txd, "R10 idle line high", int'(txd), 1);

        // R5/R6/R7: directed, ticks held off
        par_mode = 3'd1;
        write(8'hA5, acc);
        chk(acc, "R5 write accepted", int'(acc), 1);
        chk(!tx_ready, "R5 ready low after write", int'(tx_ready), 0);
        write(8'h3C, acc);
        chk(!acc, "R7 write while not ready", int'(acc), 0);
        for (int i = 0; i < 5; i++) step();
        chk(!tx_ready, "R6 no load without tick", int'(tx_ready), 0);
        chk(txd, "R6 line high before load", int'(txd), 1);
        baud_tick = 1'b1;
        step();
        baud_tick = 1'b0;
        chk(tx_ready, "R6 ready after load tick", int'(tx_ready), 1);
        chk(!txd, "R3 start bit after load", int'(txd), 0);
        chk(!tx_empty, "R9 not empty while shifting", int'(tx_empty), 0);

        // R8: second write during shifting, back-to-back reload
        write(8'h5A, acc);
        chk(acc, "R8 second write accepted", int'(acc), 1);
        write(8'hFF, acc);
        chk(!acc, "R7 third write ignored", int'(acc), 0);
        tick_rand = 1'b1;
        for (int i = 0; i < 100; i++) step();
        chk(!tx_ready, "R8 ready low mid frame", int'(tx_ready), 0);
        for (int i = 0; i < 20000 && !tx_ready; i++) step();
        chk(tx_ready, "R8 ready returns", int'(tx_ready), 1);
        chk(in_frame && since == 0, "R8 second start on reload tick", since, 0);
        chk(last_gap == TPB * 11, "R8 no gap between frames", last_gap, TPB * 11);
        wait_empty();
        chk(expq.size() == 0, "R7 only accepted chars sent", expq.size(), 0);

        // R1: disable mid-frame
        par_mode = 3'd0;
        write(8'h81, acc);
        for (int i = 0; i < 60; i++) step();
        tx_en = 1'b0;
        expq.delete();
        step();
        chk(txd, "R1 line high after disable", int'(txd), 1);
        chk(!tx_ready && !tx_empty, "R1 flags low after disable",
            int'({tx_ready, tx_empty}), 0);
        tx_en = 1'b1;
        step();
        chk(tx_empty && tx_ready, "R1 cleared on re-enable", int'({tx_ready, tx_empty}), 3);
        for (int i = 0; i < 600; i++) step();
        chk(txd && tx_empty, "R10 no stale frame", int'(txd), 1);

        // Random rounds: R3 R4 R8 R9 over all mode codes
        for (int r = 0; r < 24; r++) begin
            int k;
            par_mode = 3'($urandom % 8);
            k = 1 + ($urandom % 3);
            for (int j = 0; j < k; j++) begin
                for (int g = 0; g < 20000 && ($urandom % 4 != 0 || !tx_ready); g++) step();
                write(8'($urandom), acc);
                if (($urandom % 3) == 0) write(8'($urandom), acc);
            end
            wait_empty();
            chk(expq.size() == 0, "R4 all frames sent", expq.size(), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule